// File: doc/BRIEF.md
# Page Translation Cache with Referenced/Changed Tracking

This block is a small, fully associative cache of page translations for a segmented, paged address translator. Each cycle it can take one effective address together with the access kind (load, store or instruction fetch), the two translation-enable flags and a flag from the block-translation logic. One cycle later it reports how that access was resolved. An access can resolve as untranslated, as claimed by block translation, as a direct-store segment, as a cache hit with a physical address, or as a miss. A miss also reports the 52-bit virtual address, so that an external table walker can find the page entry.

The block keeps referenced/changed page history for the page table. On a miss, the walker sets the bits in memory and then returns the entry through the refill port. The cache records whether the missed access was a store, so the loaded entry already holds a changed bit when a store caused the refill. On a hit, the referenced bit in memory is taken as already set. Only a store that hits an entry whose changed bit is clear raises a changed-bit write-back request, and that entry's bit is then set so the request is issued once.

Software keeps its own copy of the history bits consistent with the cache through an invalidate-by-page port. Sixteen segment registers hold the segment identifiers and the direct-store flag, and they are loaded through a write port.

Top module: `tlb_rc`

## Requirements
- R1: After reset every cache entry is invalid, every segment register holds identifier 0 with the direct-store flag clear, and `resp_valid`, `resp_kind`, `resp_pa`, `resp_va`, `rc_cset_valid` and `rc_cset_va` are all 0. A translated access made after reset therefore resolves as a miss.
- R2: The enable that applies is `ir_en` for a fetch (`req_fetch`=1) and `dr_en` otherwise. If that enable is 0, the access resolves as kind 1 (untranslated) with `resp_pa` equal to the effective address. Such an access raises no write-back request and changes no entry.
- R3: If translation is enabled and `bat_hit` is 1, the access resolves as kind 2 with `resp_pa`=0. It raises no write-back request and leaves the entry's changed bit as it was, so a later store hit on that page still raises a request.
- R4: If translation is enabled, `bat_hit` is 0 and the segment register selected by effective-address bits [31:28] has its direct-store flag set, the access resolves as kind 3 with `resp_pa`=0 and raises no write-back request.
- R5: Every response appears in the cycle after the request, with `resp_valid`=1. A hit is kind 4. Its `resp_pa` is the entry's 20-bit physical page number above the address bits [11:0]. Its `resp_va` is {segment identifier, address bits [27:12], address bits [11:0]}.
- R6: A load or fetch hit never raises a write-back request. A store hit on an entry whose changed bit is 0 raises `rc_cset_valid`, with `rc_cset_va` equal to `resp_va`, in the response cycle, and it sets the entry's changed bit. A store hit on an entry whose changed bit is 1 raises no request.
- R7: A miss is kind 5, with `resp_pa`=0 and `resp_va` formed as in R5.
- R8: Refills fill entry slots in round-robin order. The order starts at slot 0 after reset and wraps after the last slot, so the refill that follows ENTRIES refills replaces the oldest one.
- R9: The changed bit of a refilled entry is `refill_c` OR'd with whether the most recent miss was a store.
- R10: An invalidate makes invalid every entry whose page index equals `inval_ea`[27:12], whatever its segment. Other entries stay valid. After the invalidate, the next access to that page misses.
- R11: A segment register write (`seg_wr_en`) applies from the following cycle onward. A later access through that segment is looked up and reported with the new identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 4 | Segment register number |
| seg_wr_vsid | input | 24 | Segment identifier to write |
| seg_wr_dstore | input | 1 | Direct-store flag to write |
| req_valid | input | 1 | Access request present |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| ir_en | input | 1 | Instruction translation enabled |
| dr_en | input | 1 | Data translation enabled |
| bat_hit | input | 1 | Block translation claimed this access |
| refill_valid | input | 1 | Refill entry from table search |
| refill_vsid | input | 24 | Refill segment identifier |
| refill_pidx | input | 16 | Refill page index |
| refill_ppn | input | 20 | Refill physical page number |
| refill_c | input | 1 | Changed bit from the page table entry |
| inval_valid | input | 1 | Invalidate request |
| inval_ea | input | 32 | Effective address whose page is invalidated |
| resp_valid | output | 1 | Response present |
| resp_kind | output | 3 | 0 none, 1 untranslated, 2 block, 3 direct-store, 4 hit, 5 miss |
| resp_pa | output | 32 | Physical address |
| resp_va | output | 52 | Virtual address (hit or miss) |
| rc_cset_valid | output | 1 | Changed-bit write-back request |
| rc_cset_va | output | 52 | Virtual address for the write-back |

## Verification
The bench builds the block with ENTRIES=4 and keeps the address, identifier and page widths at their defaults. With four slots, a fifth refill wraps the round-robin pointer and evicts the first page. This makes eviction followed by a re-miss reachable in a short sequence. The reference model also covers the other corner cases: a store miss followed by a store hit, a block-translation store between two hits, an invalidate followed by a store refill, and a segment identifier rewritten under a cached page.

// File: rtl/tlb_rc_pkg.sv
package tlb_rc_pkg;
  typedef enum logic [2:0] {
    K_NONE   = 3'd0,
    K_REAL   = 3'd1,
    K_BLOCK  = 3'd2,
    K_DSTORE = 3'd3,
    K_HIT    = 3'd4,
    K_MISS   = 3'd5
  } resp_kind_e;
endpackage

// File: rtl/tlb_segfile.sv
module tlb_segfile #(
  parameter int SEL_W  = 4,
  parameter int VSID_W = 24,
  localparam int SEGS  = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [VSID_W-1:0] wr_vsid,
  input  logic              wr_t,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [VSID_W-1:0] rd_vsid,
  output logic              rd_t
);
  logic [VSID_W-1:0] vsid_q [SEGS];
  logic [SEGS-1:0]   t_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q <= '0;
      for (int i = 0; i < SEGS; i++) vsid_q[i] <= '0;
    end else if (wr_en) begin
      vsid_q[wr_sel] <= wr_vsid;
      t_q[wr_sel]    <= wr_t;
    end
  end

  assign rd_vsid = vsid_q[rd_sel];
  assign rd_t    = t_q[rd_sel];

  // R11
  seg_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (vsid_q[$past(wr_sel)] == $past(wr_vsid)) && (t_q[$past(wr_sel)] == $past(wr_t)));
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 16,
  parameter int VSID_W  = 24,
  parameter int PIDX_W  = 16,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VSID_W-1:0] lk_vsid,
  input  logic [PIDX_W-1:0] lk_pidx,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic              lk_c,
  input  logic              cset_en,
  input  logic [IDX_W-1:0]  cset_idx,
  input  logic              inv_en,
  input  logic [PIDX_W-1:0] inv_pidx,
  input  logic              fill_en,
  input  logic [VSID_W-1:0] fill_vsid,
  input  logic [PIDX_W-1:0] fill_pidx,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic              fill_c
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] v_q, c_q, match;
  logic [VSID_W-1:0]  vsid_q [ENTRIES];
  logic [PIDX_W-1:0]  pidx_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];
  logic [IDX_W-1:0]   ptr_q;

  // status bits: changed-bit set, then invalidate, then refill (refill wins)
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      c_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (cset_en && cset_idx == IDX_W'(i)) c_q[i] <= 1'b1;
        if (inv_en && pidx_q[i] == inv_pidx) v_q[i] <= 1'b0;
        if (fill_en && ptr_q == IDX_W'(i)) begin
          v_q[i] <= 1'b1;
          c_q[i] <= fill_c;
        end
      end
    end
  end

  // tag and page payload, written only on refill
  always_ff @(posedge clk) begin
    if (fill_en) begin
      vsid_q[ptr_q] <= fill_vsid;
      pidx_q[ptr_q] <= fill_pidx;
      ppn_q[ptr_q]  <= fill_ppn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (fill_en) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = v_q[g] && (vsid_q[g] == lk_vsid) && (pidx_q[g] == lk_pidx);
  end

  always_comb begin
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (match[i]) lk_idx = IDX_W'(i);
  end

  assign lk_hit = |match;
  assign lk_ppn = ppn_q[lk_idx];
  assign lk_c   = c_q[lk_idx];

  // R8
  rr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));
  // R9
  fill_c_chk: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> v_q[$past(ptr_q)] && (c_q[$past(ptr_q)] == $past(fill_c)));
  // R5
  match_unique_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(match));
endmodule

// File: rtl/tlb_rc.sv
module tlb_rc
  import tlb_rc_pkg::*;
#(
  parameter int ENTRIES  = 16,
  parameter int EA_W     = 32,
  parameter int SEG_BITS = 4,
  parameter int OFF_W    = 12,
  parameter int VSID_W   = 24,
  localparam int PIDX_W  = EA_W - SEG_BITS - OFF_W,
  localparam int PPN_W   = EA_W - OFF_W,
  localparam int VA_W    = VSID_W + PIDX_W + OFF_W,
  localparam int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seg_wr_en,
  input  logic [SEG_BITS-1:0] seg_wr_sel,
  input  logic [VSID_W-1:0] seg_wr_vsid,
  input  logic              seg_wr_dstore,
  input  logic              req_valid,
  input  logic [EA_W-1:0]   req_ea,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              ir_en,
  input  logic              dr_en,
  input  logic              bat_hit,
  input  logic              refill_valid,
  input  logic [VSID_W-1:0] refill_vsid,
  input  logic [PIDX_W-1:0] refill_pidx,
  input  logic [PPN_W-1:0]  refill_ppn,
  input  logic              refill_c,
  input  logic              inval_valid,
  input  logic [EA_W-1:0]   inval_ea,
  output logic              resp_valid,
  output logic [2:0]        resp_kind,
  output logic [EA_W-1:0]   resp_pa,
  output logic [VA_W-1:0]   resp_va,
  output logic              rc_cset_valid,
  output logic [VA_W-1:0]   rc_cset_va
);
  logic [SEG_BITS-1:0] seg_sel;
  logic [PIDX_W-1:0]   pidx;
  logic [OFF_W-1:0]    off;
  logic [VSID_W-1:0]   seg_vsid;
  logic                seg_t;
  logic                lk_hit, lk_c;
  logic [IDX_W-1:0]    lk_idx;
  logic [PPN_W-1:0]    lk_ppn;
  logic                xl_on;

  resp_kind_e          kind_d, kind_q;
  logic [EA_W-1:0]     pa_d, pa_q;
  logic [VA_W-1:0]     va_d, va_q, csva_q;
  logic                cset_d, cset_q, miss_store_q;

  assign seg_sel = req_ea[EA_W-1 -: SEG_BITS];
  assign pidx    = req_ea[OFF_W +: PIDX_W];
  assign off     = req_ea[OFF_W-1:0];
  assign xl_on   = req_fetch ? ir_en : dr_en;

  tlb_segfile #(.SEL_W(SEG_BITS), .VSID_W(VSID_W)) u_seg (
    .clk(clk), .rst(rst),
    .wr_en(seg_wr_en), .wr_sel(seg_wr_sel), .wr_vsid(seg_wr_vsid), .wr_t(seg_wr_dstore),
    .rd_sel(seg_sel), .rd_vsid(seg_vsid), .rd_t(seg_t)
  );

  tlb_cam #(.ENTRIES(ENTRIES), .VSID_W(VSID_W), .PIDX_W(PIDX_W), .PPN_W(PPN_W)) u_cam (
    .clk(clk), .rst(rst),
    .lk_vsid(seg_vsid), .lk_pidx(pidx),
    .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_c(lk_c),
    .cset_en(cset_d), .cset_idx(lk_idx),
    .inv_en(inval_valid), .inv_pidx(inval_ea[OFF_W +: PIDX_W]),
    .fill_en(refill_valid), .fill_vsid(refill_vsid), .fill_pidx(refill_pidx),
    .fill_ppn(refill_ppn), .fill_c(refill_c | miss_store_q)
  );

  always_comb begin
    kind_d = K_NONE;
    pa_d   = '0;
    va_d   = '0;
    cset_d = 1'b0;
    if (req_valid) begin
      if (!xl_on) begin
        kind_d = K_REAL;
        pa_d   = req_ea;
      end else if (bat_hit) begin
        kind_d = K_BLOCK;
      end else if (seg_t) begin
        kind_d = K_DSTORE;
      end else begin
        va_d = {seg_vsid, pidx, off};
        if (lk_hit) begin
          kind_d = K_HIT;
          pa_d   = {lk_ppn, off};
          cset_d = req_write && !lk_c;
        end else begin
          kind_d = K_MISS;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_q       <= K_NONE;
      pa_q         <= '0;
      va_q         <= '0;
      cset_q       <= 1'b0;
      csva_q       <= '0;
      miss_store_q <= 1'b0;
    end else begin
      kind_q <= kind_d;
      pa_q   <= pa_d;
      va_q   <= va_d;
      cset_q <= cset_d;
      csva_q <= cset_d ? va_d : '0;
      if (kind_d == K_MISS) miss_store_q <= req_write;
    end
  end

  assign resp_valid    = (kind_q != K_NONE);
  assign resp_kind     = kind_q;
  assign resp_pa       = pa_q;
  assign resp_va       = va_q;
  assign rc_cset_valid = cset_q;
  assign rc_cset_va    = csva_q;

  // R2
  real_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_kind == K_REAL) |-> (resp_pa == $past(req_ea)));
  // R6
  cset_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rc_cset_valid |-> (resp_valid && resp_kind == K_HIT && rc_cset_va == resp_va));
  // R6
  cset_once_chk: assert property (@(posedge clk) disable iff (rst)
    (rc_cset_valid && !$past(refill_valid)) |=> !(rc_cset_valid && rc_cset_va[VA_W-1:OFF_W] == $past(rc_cset_va[VA_W-1:OFF_W])));
  // R5
  resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
endmodule

// File: tb/tlb_rc_test.sv
`timescale 1ns/1ps
module tlb_rc_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        seg_wr_en = 0, seg_wr_dstore = 0;
  logic [3:0]  seg_wr_sel = 0;
  logic [23:0] seg_wr_vsid = 0;
  logic        req_valid = 0, req_write = 0, req_fetch = 0, ir_en = 0, dr_en = 0, bat_hit = 0;
  logic [31:0] req_ea = 0;
  logic        refill_valid = 0, refill_c = 0;
  logic [23:0] refill_vsid = 0;
  logic [15:0] refill_pidx = 0;
  logic [19:0] refill_ppn = 0;
  logic        inval_valid = 0;
  logic [31:0] inval_ea = 0;
  logic        resp_valid, rc_cset_valid;
  logic [2:0]  resp_kind;
  logic [31:0] resp_pa;
  logic [51:0] resp_va, rc_cset_va;

  tlb_rc #(.ENTRIES(N)) uut (
    .clk(clk), .rst(rst),
    .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_vsid(seg_wr_vsid),
    .seg_wr_dstore(seg_wr_dstore),
    .req_valid(req_valid), .req_ea(req_ea), .req_write(req_write), .req_fetch(req_fetch),
    .ir_en(ir_en), .dr_en(dr_en), .bat_hit(bat_hit),
    .refill_valid(refill_valid), .refill_vsid(refill_vsid), .refill_pidx(refill_pidx),
    .refill_ppn(refill_ppn), .refill_c(refill_c),
    .inval_valid(inval_valid), .inval_ea(inval_ea),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_pa(resp_pa), .resp_va(resp_va),
    .rc_cset_valid(rc_cset_valid), .rc_cset_va(rc_cset_va)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural reference state
  bit          m_v [N];
  bit          m_c [N];
  logic [23:0] m_vsid [N];
  logic [15:0] m_pidx [N];
  logic [19:0] m_ppn [N];
  int          m_ptr = 0;
  logic [23:0] m_segv [16];
  bit          m_segt [16];
  bit          m_mst = 0;

  function automatic logic [31:0] ea(input int seg, input int page, input int ofs);
    return {seg[3:0], page[15:0], ofs[11:0]};
  endfunction

  task automatic step(input string tag);
    int          kind = 0, hidx = -1;
    logic [31:0] pa = 0;
    logic [51:0] va = 0, csva = 0;
    bit          cs = 0, en, miss = 0;
    logic [23:0] sv;
    logic [15:0] pg;
    en = req_fetch ? ir_en : dr_en;
    sv = m_segv[req_ea[31:28]];
    pg = req_ea[27:12];
    if (req_valid) begin
      if (!en) begin kind = 1; pa = req_ea; end
      else if (bat_hit) kind = 2;
      else if (m_segt[req_ea[31:28]]) kind = 3;
      else begin
        va = {sv, pg, req_ea[11:0]};
        for (int i = N - 1; i >= 0; i--)
          if (m_v[i] && m_vsid[i] == sv && m_pidx[i] == pg) hidx = i;
        if (hidx >= 0) begin
          kind = 4;
          pa = {m_ppn[hidx], req_ea[11:0]};
          if (req_write && !m_c[hidx]) begin cs = 1; csva = va; end
        end else begin
          kind = 5; miss = 1;
        end
      end
    end
    // state updates in order: segment, changed bit, invalidate, refill, miss kind
    if (seg_wr_en) begin m_segv[seg_wr_sel] = seg_wr_vsid; m_segt[seg_wr_sel] = seg_wr_dstore; end
    if (cs) m_c[hidx] = 1;
    if (inval_valid)
      for (int i = 0; i < N; i++) if (m_pidx[i] == inval_ea[27:12]) m_v[i] = 0;
    if (refill_valid) begin
      m_v[m_ptr] = 1; m_c[m_ptr] = refill_c | m_mst;
      m_vsid[m_ptr] = refill_vsid; m_pidx[m_ptr] = refill_pidx; m_ppn[m_ptr] = refill_ppn;
      m_ptr = (m_ptr + 1) % N;
    end
    if (miss) m_mst = req_write;
    @(posedge clk); #1;
    checks++;
    if (resp_valid !== (kind != 0) || resp_kind !== 3'(kind) || resp_pa !== pa ||
        resp_va !== va || rc_cset_valid !== cs || rc_cset_va !== csva) begin
      failures++;
      $display("FAIL %s: actual valid=%b kind=%0d pa=%h va=%h cset=%b csva=%h expected valid=%b kind=%0d pa=%h va=%h cset=%b csva=%h",
               tag, resp_valid, resp_kind, resp_pa, resp_va, rc_cset_valid, rc_cset_va,
               kind != 0, kind, pa, va, cs, csva);
    end
    @(negedge clk);
    seg_wr_en = 0; req_valid = 0; req_write = 0; req_fetch = 0; bat_hit = 0;
    refill_valid = 0; refill_c = 0; inval_valid = 0;
  endtask

  task automatic seg(input int s, input logic [23:0] v, input bit t, input string tag);
    seg_wr_en = 1; seg_wr_sel = s[3:0]; seg_wr_vsid = v; seg_wr_dstore = t;
    step(tag);
  endtask

  task automatic acc(input logic [31:0] a, input bit wr, input bit f, input bit ir,
                     input bit dr, input bit bat, input string tag);
    req_valid = 1; req_ea = a; req_write = wr; req_fetch = f;
    ir_en = ir; dr_en = dr; bat_hit = bat;
    step(tag);
  endtask

  task automatic fill(input logic [23:0] v, input int pg, input logic [19:0] ppn,
                      input bit c, input string tag);
    refill_valid = 1; refill_vsid = v; refill_pidx = pg[15:0]; refill_ppn = ppn; refill_c = c;
    step(tag);
  endtask

  task automatic inv(input logic [31:0] a, input string tag);
    inval_valid = 1; inval_ea = a;
    step(tag);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_c[i] = 0; m_pidx[i] = 0; m_vsid[i] = 0; m_ppn[i] = 0; end
    for (int i = 0; i < 16; i++) begin m_segv[i] = 0; m_segt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    step("R1");                                   // idle outputs after reset
    acc(ea(1, 5, 'h010), 0, 0, 1, 1, 0, "R1");    // empty cache, segment 0 id -> miss
    seg(1, 24'hABCDE1, 0, "R11");
    seg(2, 24'h000222, 1, "R11");
    seg(3, 24'h123456, 0, "R11");
    acc(ea(1, 5, 'h020), 0, 0, 1, 0, 0, "R2");    // data, translation off
    acc(ea(1, 5, 'h024), 0, 1, 0, 1, 0, "R2");    // fetch uses ir_en
    acc(ea(1, 5, 'h028), 0, 1, 1, 0, 0, "R7");    // fetch translated -> miss
    acc(ea(1, 5, 'h030), 1, 0, 1, 1, 0, "R7");    // store miss
    fill(24'hABCDE1, 5, 20'h00077, 0, "R9");      // slot 0, C from store miss
    acc(ea(1, 5, 'h044), 1, 0, 1, 1, 0, "R9");    // store hit, C already set
    acc(ea(1, 5, 'hABC), 0, 1, 1, 0, 0, "R5");    // fetch hit
    acc(ea(1, 6, 'h008), 0, 0, 1, 1, 0, "R7");
    fill(24'hABCDE1, 6, 20'h12345, 0, "R8");      // slot 1, C clear
    acc(ea(1, 6, 'h100), 0, 0, 1, 1, 0, "R6");    // load hit, no request
    acc(ea(1, 6, 'h104), 1, 0, 1, 1, 0, "R6");    // store hit, request
    acc(ea(1, 6, 'h108), 1, 0, 1, 1, 0, "R6");    // store hit, no second request
    acc(ea(1, 7, 'h000), 0, 0, 1, 1, 0, "R7");
    fill(24'hABCDE1, 7, 20'hFEDCB, 0, "R8");      // slot 2
    acc(ea(1, 7, 'h010), 1, 0, 1, 1, 1, "R3");    // block translation store
    acc(ea(1, 7, 'h014), 1, 0, 1, 1, 0, "R3");    // C still clear -> request
    acc(ea(2, 7, 'h000), 1, 0, 1, 1, 0, "R4");    // direct-store segment
    acc(ea(2, 5, 'h000), 0, 1, 1, 1, 0, "R4");
    acc(ea(3, 8, 'h000), 0, 0, 1, 1, 0, "R7");
    fill(24'h123456, 8, 20'h00400, 1, "R9");      // slot 3, C from refill_c
    acc(ea(3, 8, 'h0F0), 1, 0, 1, 1, 0, "R9");
    acc(ea(1, 9, 'h000), 0, 0, 1, 1, 0, "R7");
    fill(24'hABCDE1, 9, 20'h00999, 0, "R8");      // wraps to slot 0, evicts page 5
    acc(ea(1, 5, 'h000), 0, 0, 1, 1, 0, "R8");    // page 5 now misses
    acc(ea(1, 9, 'h123), 0, 0, 1, 1, 0, "R8");
    inv(ea(3, 6, 'h000), "R10");                  // page 6 cleared in any segment
    acc(ea(1, 7, 'h200), 0, 0, 1, 1, 0, "R10");   // other page still hits
    acc(ea(1, 6, 'h000), 1, 0, 1, 1, 0, "R10");   // store miss after invalidate
    fill(24'hABCDE1, 6, 20'h12345, 0, "R10");
    acc(ea(1, 6, 'h004), 1, 0, 1, 1, 0, "R10");   // C recorded by refill
    seg(1, 24'h5A5A5A, 0, "R11");
    acc(ea(1, 9, 'h000), 0, 0, 1, 1, 0, "R11");   // new identifier -> miss
    acc(ea(3, 8, 'h000), 0, 0, 1, 1, 0, "R11");   // unchanged segment still hits
    step("R1");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule